// File: doc/BRIEF.md
# Multi-Length Accumulator ALU

This block is the arithmetic and logic unit of a 16-bit accumulator machine. Each cycle in which an operation is presented, it takes the accumulator, a second operand (already fetched from memory or taken as an immediate), the current carry, multi-length and overflow flags, and a 3-bit operation code. One clock later it presents the result, the new carry, sign, overflow, zero and multi-length flags, and a write enable for the result and for each flag. The surrounding datapath uses the enables to decide which state to update. Memory access, addressing and routing of the result lie outside the block.

Subtraction takes the accumulator away from the operand, not the reverse. When the multi-length flag is set, the incoming carry joins the sum, and for subtraction the carry acts as a "no borrow" bit. Compare always sets the multi-length flag. A run of compares, least significant word first, therefore acts as one wide compare.

The control is a two-state machine. `ST_IDLE` means no result is pending and `ST_DONE` means a result is on the outputs. The machine goes from `ST_IDLE` to `ST_DONE` when `op_valid` is high. It stays in `ST_DONE` while `op_valid` stays high, and returns to `ST_IDLE` on the first cycle without `op_valid`. `res_valid` is high exactly in `ST_DONE`. The data outputs are registered alongside the state. While idle they hold their last values.

Top module: `mlalu`

## Requirements
- R1: With op_code 0 (add), result = (opnd_in + acc_in + cin) mod 2^16, where cin = c_in if m_in is 1 and 0 otherwise. flag_c is the carry out of bit 15.
- R2: With op_code 1 (subtract) and op_code 2 (compare), result = (opnd_in − acc_in − borrow) mod 2^16, where borrow = 1 − c_in if m_in is 1 and 0 otherwise. flag_c is 1 when the exact difference is non-negative (no borrow) and 0 otherwise.
- R3: For add, subtract and compare, flag_v is 1 exactly when the signed (two's complement) result of the operation falls outside −32768..32767.
- R4: Compare writes flag_m = 1 (we_m = 1) and drives res_we = 0. All other opcodes except 7 drive res_we = 1. Add and subtract do not write m (we_m = 0, flag_m = m_in).
- R5: For opcodes 0..6, we_z and we_s are 1, flag_z = 1 exactly when the 16-bit result is zero, and flag_s equals result bit 15.
- R6: Opcode 3 gives acc_in & opnd_in with flag_c = 1, and opcode 4 gives acc_in ^ opnd_in with flag_c = 0 (we_c = 1 for both). For both, the overflow flag is not written: we_v = 0 and flag_v = v_in.
- R7: Opcode 5 (load) gives result = opnd_in and opcode 6 (store) gives result = acc_in. Both write flag_v = 0 (we_v = 1) and do not write carry or multi-length (we_c = we_m = 0, flag_c = c_in, flag_m = m_in).
- R8: Results and flags appear, with res_valid = 1, on the clock edge after the edge that samples op_valid = 1. After an edge with op_valid = 0, res_valid is 0 and every other output keeps its value.
- R9: Opcode 7 is a no-operation: result = 0, flag_z = flag_s = 0, res_we and all flag enables are 0, and flag_c, flag_m and flag_v pass c_in, m_in and v_in through.
- R10: While rst_n is low, res_valid, result, res_we, all flags and all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation: 0 add, 1 sub, 2 compare, 3 and, 4 xor, 5 load, 6 store, 7 none |
| acc_in | input | 16 | Accumulator value |
| opnd_in | input | 16 | Operand value |
| c_in | input | 1 | Current carry flag |
| m_in | input | 1 | Current multi-length flag |
| v_in | input | 1 | Current overflow flag |
| res_valid | output | 1 | Outputs below belong to a completed operation |
| result | output | 16 | Computed value |
| res_we | output | 1 | Result should be written back |
| flag_c | output | 1 | New carry |
| flag_s | output | 1 | New sign |
| flag_v | output | 1 | New overflow |
| flag_z | output | 1 | New zero |
| flag_m | output | 1 | New multi-length |
| we_c | output | 1 | Carry is written |
| we_s | output | 1 | Sign is written |
| we_v | output | 1 | Overflow is written |
| we_z | output | 1 | Zero is written |
| we_m | output | 1 | Multi-length is written |

## Verification
The bench goes after the direction of subtraction and the carry-as-no-borrow rule. A design that computed acc − opnd, or that left the carry as a borrow, would give wrong words when two 16-bit subtracts are chained into a 32-bit difference. It also tests overflow at the edges of the signed range, such as 0x7FFF + 1 and 0x8000 − 1. A design that tested only the result sign, or that took the wrong operand as the subtrahend, would misreport those cases. The remaining checks confirm that compare forces the multi-length flag on while suppressing the result write, that AND and XOR leave the overflow enable low and pass the old value through, and that idle cycles change nothing.

// File: rtl/mlalu_pkg.sv
package mlalu_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_CMP   = 3'd2,
        OP_AND   = 3'd3,
        OP_XOR   = 3'd4,
        OP_LOAD  = 3'd5,
        OP_STORE = 3'd6,
        OP_NONE  = 3'd7
    } alu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } alu_state_e;

    typedef struct packed {
        logic c;
        logic s;
        logic v;
        logic z;
        logic m;
    } flag_set_t;

endpackage

// File: rtl/mlalu_arith.sv
module mlalu_arith #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] wide;

    always_comb begin
        wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
        sum  = wide[MSB:0];
        cout = wide[WIDTH];
        // signed overflow: like-signed inputs, result of the other sign
        ovf  = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
    end
endmodule

// File: rtl/mlalu_logic.sv
module mlalu_logic #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             pick_xor,
    output logic [WIDTH-1:0] r
);
    always_comb begin
        if (pick_xor) r = a ^ b;
        else          r = a & b;
    end
endmodule

// File: rtl/mlalu_zs.sv
module mlalu_zs #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] val,
    output logic             is_zero,
    output logic             is_neg
);
    always_comb begin
        is_zero = (val == '0);
        is_neg  = val[WIDTH-1];
    end
endmodule

// File: rtl/mlalu.sv
module mlalu
    import mlalu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0] opnd_in,
    input  logic             c_in,
    input  logic             m_in,
    input  logic             v_in,
    output logic             res_valid,
    output logic [WIDTH-1:0] result,
    output logic             res_we,
    output logic             flag_c,
    output logic             flag_s,
    output logic             flag_v,
    output logic             flag_z,
    output logic             flag_m,
    output logic             we_c,
    output logic             we_s,
    output logic             we_v,
    output logic             we_z,
    output logic             we_m
);
    alu_state_e state, state_nxt;
    alu_op_e    op, op_q;

    logic             is_sub;
    logic [WIDTH-1:0] y_sel;
    logic             cin_sel;
    logic [WIDTH-1:0] sum;
    logic             cout, ovf;
    logic [WIDTH-1:0] logic_r;
    logic [WIDTH-1:0] nxt_res;
    logic             zs_z, zs_s;
    logic             nxt_res_we;
    flag_set_t        nxt_flg, nxt_we;

    assign op      = alu_op_e'(op_code);
    assign is_sub  = (op == OP_SUB) || (op == OP_CMP);
    assign y_sel   = is_sub ? ~acc_in : acc_in;
    assign cin_sel = m_in ? c_in : is_sub;

    mlalu_arith #(.WIDTH(WIDTH)) u_arith (
        .x(opnd_in), .y(y_sel), .cin(cin_sel),
        .sum(sum), .cout(cout), .ovf(ovf)
    );

    mlalu_logic #(.WIDTH(WIDTH)) u_logic (
        .a(acc_in), .b(opnd_in), .pick_xor(op == OP_XOR), .r(logic_r)
    );

    mlalu_zs #(.WIDTH(WIDTH)) u_zs (
        .val(nxt_res), .is_zero(zs_z), .is_neg(zs_s)
    );

    // operation decode: value and enables for every output
    always_comb begin
        nxt_res    = '0;
        nxt_res_we = 1'b1;
        nxt_flg    = '{c: c_in, s: 1'b0, v: v_in, z: 1'b0, m: m_in};
        nxt_we     = '{c: 1'b0, s: 1'b1, v: 1'b0, z: 1'b1, m: 1'b0};
        unique case (op)
            OP_ADD, OP_SUB, OP_CMP: begin
                nxt_res   = sum;
                nxt_flg.c = cout;
                nxt_flg.v = ovf;
                nxt_we.c  = 1'b1;
                nxt_we.v  = 1'b1;
                if (op == OP_CMP) begin
                    nxt_res_we = 1'b0;
                    nxt_flg.m  = 1'b1;
                    nxt_we.m   = 1'b1;
                end
            end
            OP_AND, OP_XOR: begin
                nxt_res   = logic_r;
                nxt_flg.c = (op == OP_AND);
                nxt_we.c  = 1'b1;
            end
            OP_LOAD, OP_STORE: begin
                nxt_res   = (op == OP_LOAD) ? opnd_in : acc_in;
                nxt_flg.v = 1'b0;
                nxt_we.v  = 1'b1;
            end
            OP_NONE: begin
                nxt_res_we = 1'b0;
                nxt_we     = '0;
            end
        endcase
        if (nxt_we.z) begin
            nxt_flg.z = zs_z;
            nxt_flg.s = zs_s;
        end
    end

    // state transition
    always_comb begin
        unique case (state)
            ST_IDLE: state_nxt = op_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_nxt = op_valid ? ST_DONE : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_NONE;
            result <= '0;
            res_we <= 1'b0;
            {flag_c, flag_s, flag_v, flag_z, flag_m} <= '0;
            {we_c, we_s, we_v, we_z, we_m}           <= '0;
        end else if (op_valid) begin
            op_q   <= op;
            result <= nxt_res;
            res_we <= nxt_res_we;
            {flag_c, flag_s, flag_v, flag_z, flag_m} <= nxt_flg;
            {we_c, we_s, we_v, we_z, we_m}           <= nxt_we;
        end
    end

    assign res_valid = (state == ST_DONE);

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && $stable(result) && $stable(flag_c))); // R8
    AST_CMP_FORCES_M: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && op_q == OP_CMP) |-> (we_m && flag_m && !res_we)); // R4
    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && we_z) |-> (flag_z == (result == '0))); // R5
    AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && op_q == OP_AND) |-> (flag_c && we_c && !we_v)); // R6
    AST_MOVE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (op_q == OP_LOAD || op_q == OP_STORE))
            |-> (!we_c && !we_m && we_v && !flag_v)); // R7
    AST_NOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && op_q == OP_NONE) |-> !(res_we || we_c || we_s || we_v || we_z || we_m)); // R9
endmodule

// File: tb/test_mlalu.sv
module test_mlalu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd7;
    logic [15:0] acc_in = '0, opnd_in = '0;
    logic        c_in = 1'b0, m_in = 1'b0, v_in = 1'b0;
    logic        res_valid, res_we;
    logic [15:0] result;
    logic        flag_c, flag_s, flag_v, flag_z, flag_m;
    logic        we_c, we_s, we_v, we_z, we_m;

    int checks = 0;
    int errors = 0;

    // expected outputs, carried from cycle to cycle
    logic        e_valid = 0, e_rwe = 0;
    logic [15:0] e_res = 0;
    logic        e_c = 0, e_s = 0, e_v = 0, e_z = 0, e_m = 0;
    logic        e_wc = 0, e_ws = 0, e_wv = 0, e_wz = 0, e_wm = 0;
    string       cur_tag = "R10";

    always #4 clk = ~clk;

    mlalu i_mlalu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_in(acc_in), .opnd_in(opnd_in), .c_in(c_in), .m_in(m_in), .v_in(v_in),
        .res_valid(res_valid), .result(result), .res_we(res_we),
        .flag_c(flag_c), .flag_s(flag_s), .flag_v(flag_v), .flag_z(flag_z), .flag_m(flag_m),
        .we_c(we_c), .we_s(we_s), .we_v(we_v), .we_z(we_z), .we_m(we_m)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(cur_tag, "res_valid", res_valid, e_valid);
        chk(cur_tag, "result", result, e_res);
        chk(cur_tag, "res_we", res_we, e_rwe);
        chk(cur_tag, "flag_c", flag_c, e_c);
        chk(cur_tag, "flag_s", flag_s, e_s);
        chk(cur_tag, "flag_v", flag_v, e_v);
        chk(cur_tag, "flag_z", flag_z, e_z);
        chk(cur_tag, "flag_m", flag_m, e_m);
        chk(cur_tag, "we_c", we_c, e_wc);
        chk(cur_tag, "we_s", we_s, e_ws);
        chk(cur_tag, "we_v", we_v, e_wv);
        chk(cur_tag, "we_z", we_z, e_wz);
        chk(cur_tag, "we_m", we_m, e_wm);
    endtask

    // behavioural reference on plain integers
    task automatic model(input logic vld, input logic [2:0] op, input logic [15:0] a,
                         input logic [15:0] o, input logic c, input logic m, input logic v);
        int t, sv, sa, so, cin, bor;
        if (!vld) begin
            e_valid = 0;
            return;
        end
        e_valid = 1;
        sa = int'($signed(a));
        so = int'($signed(o));
        e_rwe = 1; e_m = m; e_wm = 0;
        e_c = c; e_v = v; e_wc = 0; e_wv = 0; e_ws = 1; e_wz = 1;
        case (op)
            3'd0: begin
                cin = m ? int'(c) : 0;
                t = int'(o) + int'(a) + cin;
                e_res = t[15:0]; e_c = t[16];
                sv = so + sa + cin;
                e_v = (sv > 32767) || (sv < -32768);
                e_wc = 1; e_wv = 1;
            end
            3'd1, 3'd2: begin
                bor = (m && !c) ? 1 : 0;
                t = int'(o) - int'(a) - bor;
                e_res = t[15:0]; e_c = (t >= 0);
                sv = so - sa - bor;
                e_v = (sv > 32767) || (sv < -32768);
                e_wc = 1; e_wv = 1;
                if (op == 3'd2) begin e_rwe = 0; e_m = 1; e_wm = 1; end
            end
            3'd3: begin e_res = a & o; e_c = 1; e_wc = 1; end
            3'd4: begin e_res = a ^ o; e_c = 0; e_wc = 1; end
            3'd5: begin e_res = o; e_v = 0; e_wv = 1; end
            3'd6: begin e_res = a; e_v = 0; e_wv = 1; end
            default: begin
                e_res = 0; e_rwe = 0; e_ws = 0; e_wz = 0;
            end
        endcase
        if (e_wz) begin
            e_z = (e_res == 16'h0);
            e_s = e_res[15];
        end else begin
            e_z = 0; e_s = 0;
        end
    endtask

    task automatic step(input string tag, input logic vld, input logic [2:0] op,
                        input logic [15:0] a, input logic [15:0] o,
                        input logic c, input logic m, input logic v);
        @(negedge clk);
        compare_all();
        op_valid = vld; op_code = op; acc_in = a; opnd_in = o;
        c_in = c; m_in = m; v_in = v;
        model(vld, op, a, o, c, m, v);
        cur_tag = tag;
    endtask

    task automatic chain_sub(input logic [31:0] x, input logic [31:0] y);
        logic [15:0] lo, hi;
        logic        cl;
        logic [31:0] ref32;
        step("R2", 1, 3'd1, y[15:0], x[15:0], 1'b1, 1'b1, 1'b0);
        step("R2", 0, 3'd7, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
        lo = result; cl = flag_c;
        step("R2", 1, 3'd1, y[31:16], x[31:16], cl, 1'b1, 1'b0);
        step("R2", 0, 3'd7, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
        hi = result;
        ref32 = x - y;
        chk("R2", "chained 32-bit difference", int'({hi, lo}), int'(ref32));
        chk("R2", "chained no-borrow", int'(flag_c), int'(x >= y));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        // R10: reset state
        step("R10", 0, 3'd7, 16'h0, 16'h0, 0, 0, 0);
        rst_n = 1'b1;
        step("R10", 0, 3'd7, 16'h0, 16'h0, 0, 0, 0);
        // R1 add, with and without incoming carry
        step("R1", 1, 3'd0, 16'h1234, 16'h1111, 1, 0, 0);
        step("R1", 1, 3'd0, 16'hFFFF, 16'h0001, 0, 0, 0);
        step("R1", 1, 3'd0, 16'h00FF, 16'h0F00, 1, 1, 0);
        step("R1", 1, 3'd0, 16'hFFFF, 16'h0000, 1, 1, 0);
        // R3 overflow edges
        step("R3", 1, 3'd0, 16'h7FFF, 16'h0001, 0, 0, 0);
        step("R3", 1, 3'd0, 16'h8000, 16'h8000, 0, 0, 0);
        step("R3", 1, 3'd1, 16'h0001, 16'h8000, 0, 0, 0);
        step("R3", 1, 3'd1, 16'hFFFF, 16'h7FFF, 0, 0, 0);
        // R2 subtract: operand minus accumulator, carry as no-borrow
        step("R2", 1, 3'd1, 16'h0005, 16'h0003, 0, 0, 0);
        step("R2", 1, 3'd1, 16'h0003, 16'h0005, 0, 0, 0);
        step("R2", 1, 3'd1, 16'h0003, 16'h0005, 0, 1, 0);
        step("R2", 1, 3'd1, 16'h0005, 16'h0005, 1, 1, 0);
        // R4 compare
        step("R4", 1, 3'd2, 16'h0010, 16'h0010, 0, 0, 1);
        step("R4", 1, 3'd2, 16'h0020, 16'h0010, 1, 1, 0);
        // R5 zero and sign through logic
        step("R5", 1, 3'd4, 16'hA5A5, 16'hA5A5, 1, 0, 0);
        step("R5", 1, 3'd3, 16'hF000, 16'h8001, 0, 0, 0);
        // R6 AND / XOR with overflow left untouched
        step("R6", 1, 3'd3, 16'h0F0F, 16'h3C3C, 0, 1, 1);
        step("R6", 1, 3'd4, 16'h0F0F, 16'h3C3C, 1, 0, 1);
        step("R6", 1, 3'd4, 16'h1234, 16'h4321, 1, 1, 0);
        // R7 load / store
        step("R7", 1, 3'd5, 16'h1111, 16'h8000, 1, 1, 1);
        step("R7", 1, 3'd6, 16'h0000, 16'hFFFF, 0, 1, 1);
        // R9 reserved code
        step("R9", 1, 3'd7, 16'h1234, 16'h5678, 1, 0, 1);
        // R8 idle cycles hold everything
        step("R8", 1, 3'd0, 16'h0102, 16'h0304, 0, 0, 0);
        step("R8", 0, 3'd1, 16'hFFFF, 16'hFFFF, 1, 1, 1);
        step("R8", 0, 3'd3, 16'h0000, 16'h0000, 0, 0, 0);
        step("R8", 1, 3'd5, 16'h0000, 16'h0000, 0, 0, 0);
        step("R8", 1, 3'd6, 16'h8000, 16'h0000, 0, 0, 0);
        // R2 chained 32-bit subtracts
        chain_sub(32'h0001_0000, 32'h0000_0001);
        chain_sub(32'h1234_5678, 32'h1234_5679);
        chain_sub(32'hFFFF_FFFF, 32'h8000_0001);
        chain_sub(32'h0000_0000, 32'h0000_0000);
        // R4 two-word compare: high word equal, low word decides
        step("R4", 1, 3'd2, 16'h0002, 16'h0001, 1, 1, 0);
        step("R4", 1, 3'd2, 16'h7000, 16'h7000, 0, 1, 0);
        step("R4", 0, 3'd7, 16'h0, 16'h0, 0, 0, 0);
        step("R4", 0, 3'd7, 16'h0, 16'h0, 0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule